// File: doc/BRIEF.md
# Single-Level Trap Entry Sequencer

This block carries out trap entry for an integer pipeline that uses register windows and has no trap nesting. When the trap selector raises a request with an 8-bit trap type, the sequencer does four things. It forms the handler address from the trap base register and the trap type. It moves the current window pointer down by one window. It stores the trapped PC and next-PC into the local registers of the new window. It updates the processor state fields: traps are disabled, supervisor mode is entered, and the old supervisor bit is kept.

Entry takes a fixed three cycles after the request is accepted. It ends with a redirect of fetch to the handler vector and the vector plus 4. A request that arrives while the enable-traps bit is already clear does not enter a handler. Instead it raises a one-cycle watchdog-reset pulse. The surrounding processor owns the state and trap base registers. It applies the write strobes this block produces.

Top module: `trap_entry_seq`

## Requirements
- R1: The redirect PC equals {tbr_base, trap_type, 4'b0000}, so the trap type occupies bits [11:4] of a 4096-byte-aligned table. The redirect next-PC equals that vector plus 4.
- R2: On a trap, psr_cwp_nxt equals psr_cwp minus one, modulo NWIN (default 8). A pointer of 0 becomes NWIN-1. This applies to every trap type.
- R3: In the first cycle after an accepted request, the register file is written with the trapped PC. The write goes to rf_win set to the new window and rf_idx set to 17, which is local register 1 in the 32-register window view.
- R4: In the next cycle, the trapped next-PC is written to rf_idx 18 (local register 2) of the same window.
- R5: The state update (psr_we) happens in the same cycle as the R3 write. It sets psr_et_nxt to 0 and psr_s_nxt to 1, and it copies the old supervisor bit into psr_ps_nxt.
- R6: In the same cycle as R5, tbr_we is raised and tbr_tt carries the accepted trap type.
- R7: A request seen while psr_et is 0 produces wdog_reset high for exactly one cycle, in the cycle after the request. It produces no register-file, state or trap-base write and no redirect.
- R8: redirect_valid rises exactly three cycles after the accepting edge. busy is high for those three cycles. Requests that arrive while busy is high are ignored.
- R9: After reset, busy, rf_we, psr_we, tbr_we, redirect_valid and wdog_reset are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take-trap request from the selector |
| trap_type | input | 8 | Trap type of the request |
| pc | input | 32 | PC of the trapped instruction |
| npc | input | 32 | Next-PC at the trap |
| psr_cwp | input | 3 | Current window pointer |
| psr_et | input | 1 | Enable-traps bit |
| psr_s | input | 1 | Supervisor bit |
| tbr_base | input | 20 | Trap table base, address bits [31:12] |
| busy | output | 1 | Trap entry in progress |
| psr_we | output | 1 | Write strobe for the state fields |
| psr_cwp_nxt | output | 3 | New window pointer |
| psr_et_nxt | output | 1 | New enable-traps bit |
| psr_s_nxt | output | 1 | New supervisor bit |
| psr_ps_nxt | output | 1 | New previous-supervisor bit |
| tbr_we | output | 1 | Write strobe for the trap-type field of the base register |
| tbr_tt | output | 8 | Trap type for the base register |
| rf_we | output | 1 | Register-file write strobe |
| rf_win | output | 3 | Window for the register-file write |
| rf_idx | output | 5 | Register index within the window |
| rf_wdata | output | 32 | Register-file write data |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Handler vector |
| redirect_npc | output | 32 | Handler vector plus 4 |
| wdog_reset | output | 1 | Watchdog-reset pulse for a trap taken with traps disabled |

## Verification
A wrong sequencer state shows up within one to three cycles. It appears as a missing, repeated or out-of-order write strobe, or as a redirect on the wrong cycle. The bench's scoreboard catches all of these because it tags each expected event with its cycle. A bad latch of the captured PC, next-PC, window or type shows up in the data of the L1 or L2 write, or in the redirect address of the same entry. Wrap of window 0, the extreme trap types and a request held through busy are each driven on purpose.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WR_L1 = 3'd1,
      ST_WR_L2 = 3'd2,
      ST_JUMP  = 3'd3,
      ST_WDOG  = 3'd4
   } trap_state_e;

   localparam int unsigned REG_IDX_W = 5;
   // locals occupy indices 16..23 of the per-window register view
   localparam logic [REG_IDX_W-1:0] IDX_LOCAL1 = 5'd17;
   localparam logic [REG_IDX_W-1:0] IDX_LOCAL2 = 5'd18;
endpackage

// File: rtl/trap_win_dec.sv
module trap_win_dec #(
   parameter int unsigned NWIN = 8,
   localparam int unsigned CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic [CWPW-1:0] cwp,
   output logic [CWPW-1:0] cwp_dec
);
   generate
      if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
         assign cwp_dec = cwp - 1'b1;
      end else begin : g_mod
         assign cwp_dec = (cwp == '0) ? CWPW'(NWIN - 1) : cwp - 1'b1;
      end
   endgenerate
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned TT_W     = 8,
   parameter int unsigned ENTRY_SH = 4,
   localparam int unsigned BASE_W  = XLEN - TT_W - ENTRY_SH
) (
   input  logic [BASE_W-1:0] base,
   input  logic [TT_W-1:0]   tt,
   output logic [XLEN-1:0]   vec_pc,
   output logic [XLEN-1:0]   vec_npc
);
   assign vec_pc  = {base, tt, {ENTRY_SH{1'b0}}};
   assign vec_npc = vec_pc + XLEN'(4);
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
   import trap_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        trap_req,
   input  logic        traps_on,
   output trap_state_e state,
   output logic        accept
);
   trap_state_e state_n;

   assign accept = (state == ST_IDLE) && trap_req && traps_on;

   always_comb begin
      state_n = state;
      unique case (state)
         ST_IDLE: begin
            if (trap_req) state_n = traps_on ? ST_WR_L1 : ST_WDOG;
         end
         ST_WR_L1: state_n = ST_WR_L2;
         ST_WR_L2: state_n = ST_JUMP;
         ST_JUMP:  state_n = ST_IDLE;
         ST_WDOG:  state_n = ST_IDLE;
         default:  state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_n;
   end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
   import trap_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned TT_W     = 8,
   parameter int unsigned ENTRY_SH = 4,
   parameter int unsigned NWIN     = 8,
   localparam int unsigned CWPW    = (NWIN > 1) ? $clog2(NWIN) : 1,
   localparam int unsigned BASE_W  = XLEN - TT_W - ENTRY_SH
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trap_req,
   input  logic [TT_W-1:0]      trap_type,
   input  logic [XLEN-1:0]      pc,
   input  logic [XLEN-1:0]      npc,
   input  logic [CWPW-1:0]      psr_cwp,
   input  logic                 psr_et,
   input  logic                 psr_s,
   input  logic [BASE_W-1:0]    tbr_base,
   output logic                 busy,
   output logic                 psr_we,
   output logic [CWPW-1:0]      psr_cwp_nxt,
   output logic                 psr_et_nxt,
   output logic                 psr_s_nxt,
   output logic                 psr_ps_nxt,
   output logic                 tbr_we,
   output logic [TT_W-1:0]      tbr_tt,
   output logic                 rf_we,
   output logic [CWPW-1:0]      rf_win,
   output logic [REG_IDX_W-1:0] rf_idx,
   output logic [XLEN-1:0]      rf_wdata,
   output logic                 redirect_valid,
   output logic [XLEN-1:0]      redirect_pc,
   output logic [XLEN-1:0]      redirect_npc,
   output logic                 wdog_reset
);
   generate
      if (NWIN < 2) begin : g_chk_nwin
         $error("trap_entry_seq: NWIN must be at least 2");
      end
      if (ENTRY_SH < 3) begin : g_chk_entry
         $error("trap_entry_seq: entries must hold two or more instructions");
      end
      if (XLEN < TT_W + ENTRY_SH + 1) begin : g_chk_xlen
         $error("trap_entry_seq: XLEN too small for base, type and entry");
      end
   endgenerate

   trap_state_e      state;
   logic             accept;
   logic [CWPW-1:0]  cwp_dec;
   logic [CWPW-1:0]  win_q;
   logic [XLEN-1:0]  pc_q, npc_q;
   logic [TT_W-1:0]  tt_q;
   logic [BASE_W-1:0] base_q;
   logic             s_q;
   logic [XLEN-1:0]  vec_pc, vec_npc;

   trap_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .trap_req (trap_req),
      .traps_on (psr_et),
      .state    (state),
      .accept   (accept)
   );

   trap_win_dec #(.NWIN(NWIN)) u_dec (
      .cwp     (psr_cwp),
      .cwp_dec (cwp_dec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q  <= '0;
         pc_q   <= '0;
         npc_q  <= '0;
         tt_q   <= '0;
         base_q <= '0;
         s_q    <= 1'b0;
      end else if (accept) begin
         win_q  <= cwp_dec;
         pc_q   <= pc;
         npc_q  <= npc;
         tt_q   <= trap_type;
         base_q <= tbr_base;
         s_q    <= psr_s;
      end
   end

   trap_vec_gen #(.XLEN(XLEN), .TT_W(TT_W), .ENTRY_SH(ENTRY_SH)) u_vec (
      .base    (base_q),
      .tt      (tt_q),
      .vec_pc  (vec_pc),
      .vec_npc (vec_npc)
   );

   assign busy           = (state == ST_WR_L1) || (state == ST_WR_L2) || (state == ST_JUMP);
   assign rf_we          = (state == ST_WR_L1) || (state == ST_WR_L2);
   assign rf_win         = win_q;
   assign rf_idx         = (state == ST_WR_L2) ? IDX_LOCAL2 : IDX_LOCAL1;
   assign rf_wdata       = (state == ST_WR_L2) ? npc_q : pc_q;
   assign psr_we         = (state == ST_WR_L1);
   assign psr_cwp_nxt    = win_q;
   assign psr_et_nxt     = 1'b0;
   assign psr_s_nxt      = 1'b1;
   assign psr_ps_nxt     = s_q;
   assign tbr_we         = (state == ST_WR_L1);
   assign tbr_tt         = tt_q;
   assign redirect_valid = (state == ST_JUMP);
   assign redirect_pc    = vec_pc;
   assign redirect_npc   = vec_npc;
   assign wdog_reset     = (state == ST_WDOG);

   // R5: state update keeps the supervisor bit sampled at the accepting edge
   assert_ps_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      psr_we |-> (psr_ps_nxt == $past(psr_s)) && psr_s_nxt && !psr_et_nxt);

   assert_win_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      psr_we |-> psr_cwp_nxt == (($past(psr_cwp) == '0) ? CWPW'(NWIN - 1)
                                                        : $past(psr_cwp) - 1'b1));

   assert_l2_after_l1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && rf_idx == IDX_LOCAL1) |=> rf_we && rf_idx == IDX_LOCAL2 && $stable(rf_win));

   assert_jump_after_l2_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && rf_idx == IDX_LOCAL2) |=> redirect_valid && !rf_we);

   assert_tt_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tbr_we |-> tbr_tt == $past(trap_type));

   assert_wdog_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wdog_reset && trap_req && !psr_et) |=> wdog_reset && !rf_we && !psr_we && !redirect_valid);

   assert_one_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rf_we, redirect_valid, wdog_reset}));
endmodule

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb;
   localparam int NWIN = 8;

   typedef struct {
      int          kind;   // 0 L1 write, 1 L2 write, 2 redirect, 3 watchdog
      int          cyc;
      logic [2:0]  win;
      logic [31:0] data;
      logic [31:0] data2;
      logic        ps;
      logic [7:0]  tt;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_req = 1'b0;
   logic [7:0]  trap_type = '0;
   logic [31:0] pc = '0, npc = '0;
   logic [2:0]  psr_cwp = '0;
   logic        psr_et = 1'b1, psr_s = 1'b0;
   logic [19:0] tbr_base = '0;
   logic        busy, psr_we, psr_et_nxt, psr_s_nxt, psr_ps_nxt, tbr_we;
   logic [2:0]  psr_cwp_nxt, rf_win;
   logic [7:0]  tbr_tt;
   logic        rf_we, redirect_valid, wdog_reset;
   logic [4:0]  rf_idx;
   logic [31:0] rf_wdata, redirect_pc, redirect_npc;

   int vectors = 0, fails = 0, cyc = 0;
   exp_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   trap_entry_seq u_dut (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
      .pc(pc), .npc(npc), .psr_cwp(psr_cwp), .psr_et(psr_et), .psr_s(psr_s),
      .tbr_base(tbr_base), .busy(busy), .psr_we(psr_we), .psr_cwp_nxt(psr_cwp_nxt),
      .psr_et_nxt(psr_et_nxt), .psr_s_nxt(psr_s_nxt), .psr_ps_nxt(psr_ps_nxt),
      .tbr_we(tbr_we), .tbr_tt(tbr_tt), .rf_we(rf_we), .rf_win(rf_win),
      .rf_idx(rf_idx), .rf_wdata(rf_wdata), .redirect_valid(redirect_valid),
      .redirect_pc(redirect_pc), .redirect_npc(redirect_npc), .wdog_reset(wdog_reset)
   );

   task automatic chk(input bit ok, input string req, input string msg);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s", req, msg);
      end
   endtask

   // drive one request at a negedge; hold keeps it asserted through busy with other types
   task automatic do_trap(input logic [7:0] tt, input logic [31:0] p, input logic [31:0] np,
                          input logic [2:0] cwp, input logic et, input logic s,
                          input logic [19:0] base, input bit hold);
      exp_t e;
      int c0;
      @(negedge clk);
      trap_type = tt; pc = p; npc = np; psr_cwp = cwp; psr_et = et; psr_s = s;
      tbr_base = base; trap_req = 1'b1;
      c0 = cyc;
      if (!et) begin
         e = '{kind: 3, cyc: c0 + 1, win: 0, data: 0, data2: 0, ps: 0, tt: 0};
         q.push_back(e);
      end else begin
         e = '{kind: 0, cyc: c0 + 1, win: (cwp == 0) ? 3'(NWIN - 1) : cwp - 1,
               data: p, data2: 0, ps: s, tt: tt};
         q.push_back(e);
         e.kind = 1; e.cyc = c0 + 2; e.data = np;
         q.push_back(e);
         e.kind = 2; e.cyc = c0 + 3; e.data = {base, tt, 4'h0}; e.data2 = {base, tt, 4'h4};
         q.push_back(e);
      end
      @(negedge clk);
      if (hold && et) begin
         trap_type = ~tt; pc = 32'hDEAD_0000; psr_s = ~s; tbr_base = ~base; psr_cwp = cwp + 3'd2;
         @(negedge clk);
         trap_type = tt ^ 8'h5A;
         @(negedge clk);
      end
      trap_req = 1'b0;
      while (q.size() != 0) @(negedge clk);
   endtask

   // monitor: compare each observed action against the head of the queue
   always @(negedge clk) begin
      if (rst_n && (rf_we || redirect_valid || wdog_reset || psr_we || tbr_we)) begin
         if (q.size() == 0) begin
            chk(0, "R8", $sformatf("unexpected action at cycle %0d actual we=%b red=%b wd=%b expected none",
                cyc, rf_we, redirect_valid, wdog_reset));
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(cyc == e.cyc, "R8", $sformatf("action cycle actual %0d expected %0d", cyc, e.cyc));
            case (e.kind)
               0: begin
                  chk(rf_we && rf_idx == 5'd17 && rf_win == e.win && rf_wdata == e.data, "R3",
                      $sformatf("L1 write actual we=%b idx=%0d win=%0d d=%h expected idx=17 win=%0d d=%h",
                                rf_we, rf_idx, rf_win, rf_wdata, e.win, e.data));
                  chk(psr_we && psr_cwp_nxt == e.win, "R2",
                      $sformatf("cwp actual we=%b %0d expected %0d", psr_we, psr_cwp_nxt, e.win));
                  chk(!psr_et_nxt && psr_s_nxt && psr_ps_nxt == e.ps, "R5",
                      $sformatf("et/s/ps actual %b%b%b expected 01%b", psr_et_nxt, psr_s_nxt, psr_ps_nxt, e.ps));
                  chk(tbr_we && tbr_tt == e.tt, "R6",
                      $sformatf("tt actual we=%b %h expected %h", tbr_we, tbr_tt, e.tt));
               end
               1: chk(rf_we && rf_idx == 5'd18 && rf_win == e.win && rf_wdata == e.data && !psr_we, "R4",
                      $sformatf("L2 write actual idx=%0d win=%0d d=%h expected idx=18 win=%0d d=%h",
                                rf_idx, rf_win, rf_wdata, e.win, e.data));
               2: begin
                  chk(redirect_valid && !rf_we && redirect_pc == e.data && redirect_npc == e.data2, "R1",
                      $sformatf("vector actual %h/%h expected %h/%h", redirect_pc, redirect_npc, e.data, e.data2));
                  chk(busy, "R8", "busy low during redirect actual 0 expected 1");
               end
               default: chk(wdog_reset && !rf_we && !psr_we && !tbr_we && !redirect_valid, "R7",
                      $sformatf("watchdog actual wd=%b we=%b psr=%b tbr=%b red=%b expected 1 0 0 0 0",
                                wdog_reset, rf_we, psr_we, tbr_we, redirect_valid));
            endcase
         end
      end
   end

   initial begin
      fork
         begin
            repeat (5000) @(posedge clk);
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
         end
      join_none
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!busy && !rf_we && !psr_we && !tbr_we && !redirect_valid && !wdog_reset, "R9",
          "outputs not idle in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !rf_we && !redirect_valid && !wdog_reset, "R9", "outputs not idle after reset");

      do_trap(8'h2A, 32'h0000_1000, 32'h0000_1004, 3'd5, 1'b1, 1'b0, 20'h40001, 0); // R1 R2
      do_trap(8'h00, 32'h1234_5678, 32'h1234_567C, 3'd0, 1'b1, 1'b1, 20'hFFFFF, 0); // R2 wrap
      do_trap(8'hFF, 32'hCAFE_0010, 32'hCAFE_0020, 3'd7, 1'b1, 1'b0, 20'h00000, 0); // R1 top type
      do_trap(8'h80, 32'h8000_0000, 32'h8000_0004, 3'd1, 1'b1, 1'b1, 20'hABCDE, 1); // R8 held req
      do_trap(8'h11, 32'h5555_5555, 32'h5555_5559, 3'd3, 1'b0, 1'b1, 20'h12345, 0); // R7
      @(negedge clk);
      chk(!wdog_reset && !busy, "R7", $sformatf("pulse width actual wd=%b expected 0", wdog_reset));
      do_trap(8'h09, 32'h0000_2000, 32'h0000_2004, 3'd4, 1'b1, 1'b0, 20'h00F00, 0); // after watchdog
      do_trap(8'h3C, 32'h7777_0000, 32'h7777_0008, 3'd0, 1'b1, 1'b0, 20'h0000F, 1); // R2 wrap + hold
      repeat (4) @(negedge clk);
      chk(q.size() == 0 && !busy, "R8", $sformatf("pending items actual %0d expected 0", q.size()));
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule